// File: doc/BRIEF.md
# Supervisor Trap Vector Register

This block holds the supervisor-level trap vector: a 64-bit control register whose upper 62 bits give the word-aligned handler base and whose lowest two bits pick how traps are dispatched. Software reaches it through a plain register port with a write strobe, a 64-bit write bus and a 64-bit read bus. A write only lands where it is legal. A base that is not a canonical address is thrown away. A mode value the build does not support is thrown away as well. Each of the two fields is judged on its own within a single write.

In parallel, the block turns the current register contents into a jump target for whatever trap the core is about to take. The core supplies a flag that says whether the trap is an asynchronous interrupt, plus a 6-bit cause code. In direct dispatch every trap goes to the base. In vectored dispatch an interrupt goes to the base plus four times its cause, while a synchronous exception still goes to the base. The target is combinational and always reflects the register as it stood before the current clock edge.

Top module: `strap_vec_reg`

## Requirements
- R1: After reset the read bus returns zero (base 0, mode 0), and the trap target is zero.
- R2: The read bus returns the base in bits 63:2 and the mode in bits 1:0, and it shows a legal write from the clock edge after that write.
- R3: A write whose bits 63:49 are not all equal to bit 48 leaves the base field (bits 63:2) unchanged.
- R4: Mode value 0 (direct) is stored only when the direct-enable parameter is set, and mode value 1 (vectored) only when the vectored-enable parameter is set.
- R5: A write of mode value 2 or 3, or of a mode that the build disables, leaves the mode field unchanged, so the mode field never reads 2 or 3.
- R6: Base and mode are judged independently: a non-canonical base with a legal mode updates only the mode, and a canonical base with an illegal mode updates only the base.
- R7: With mode 0, the target for any trap equals the base shifted left by two.
- R8: With mode 1 and the interrupt flag high, the target equals the base shifted left by two plus four times the cause code, wrapping modulo 2^64.
- R9: With mode 1 and the interrupt flag low, the target equals the base shifted left by two.
- R10: A write in the same cycle as a trap does not affect that cycle's target; the target uses the register value from before the edge.
- R11: With the write strobe low the read bus keeps its value, whatever the write bus carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register |
| wr_data_i | input | 64 | Value software writes |
| rd_data_o | output | 64 | Current register contents |
| trap_irq_i | input | 1 | High when the trap is an asynchronous interrupt |
| trap_cause_i | input | 6 | Cause code of the trap |
| trap_target_o | output | 64 | Address the trap jumps to |

## Verification
Target generation and a register write can fall in the same cycle: a trap may be taken on the same cycle that software rewrites the base or the mode. The bench drives random writes and random traps together in most cycles, including writes that flip the mode between direct and vectored. It judges the target, sampled before the edge, against a model holding the pre-write value (R10), and then reads the register after the edge to confirm the legalized write.

// File: rtl/stv_pkg.sv
package stv_pkg;

    parameter int unsigned XLEN   = 64;
    parameter int unsigned MODE_W = 2;
    parameter int unsigned BASE_W = XLEN - MODE_W;

    typedef enum logic [MODE_W-1:0] {
        DISP_DIRECT = 2'd0,
        DISP_VECTOR = 2'd1
    } disp_mode_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [MODE_W-1:0] mode;
    } tvec_t;

endpackage

// File: rtl/stv_wr_legal.sv
module stv_wr_legal
    import stv_pkg::*;
#(
    parameter int unsigned VA_W      = 49,
    parameter bit          DIRECT_EN = 1'b1,
    parameter bit          VECTOR_EN = 1'b1
) (
    input  tvec_t            cur_i,
    input  logic             wr_en_i,
    input  logic [XLEN-1:0]  wr_data_i,
    output tvec_t            nxt_o
);

    localparam int unsigned EXT_W = XLEN - VA_W + 1;

    logic [EXT_W-1:0] ext_bits;
    logic             base_ok;
    logic             mode_ok;
    logic [MODE_W-1:0] wr_mode;

    always_comb begin
        ext_bits = wr_data_i[XLEN-1:VA_W-1];
        base_ok  = (&ext_bits) || !(|ext_bits);
        wr_mode  = wr_data_i[MODE_W-1:0];
        mode_ok  = 1'b0;
        if (DIRECT_EN && wr_mode == DISP_DIRECT) mode_ok = 1'b1;
        if (VECTOR_EN && wr_mode == DISP_VECTOR) mode_ok = 1'b1;
    end

    always_comb begin
        nxt_o = cur_i;
        if (wr_en_i) begin
            if (base_ok) nxt_o.base = wr_data_i[XLEN-1:MODE_W];
            if (mode_ok) nxt_o.mode = wr_mode;
        end
    end

endmodule

// File: rtl/stv_target_gen.sv
module stv_target_gen
    import stv_pkg::*;
#(
    parameter int unsigned CAUSE_W = 6
) (
    input  tvec_t                cur_i,
    input  logic                 irq_i,
    input  logic [CAUSE_W-1:0]   cause_i,
    output logic [XLEN-1:0]      target_o
);

    logic [XLEN-1:0] base_addr;
    logic [XLEN-1:0] vec_off;

    always_comb begin
        base_addr = {cur_i.base, {MODE_W{1'b0}}};
        vec_off   = XLEN'(cause_i) << 2;
        if (cur_i.mode == DISP_VECTOR && irq_i)
            target_o = base_addr + vec_off;
        else
            target_o = base_addr;
    end

endmodule

// File: rtl/strap_vec_reg.sv
module strap_vec_reg
    import stv_pkg::*;
#(
    parameter int unsigned VA_W      = 49,
    parameter int unsigned CAUSE_W   = 6,
    parameter bit          DIRECT_EN = 1'b1,
    parameter bit          VECTOR_EN = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [63:0]        wr_data_i,
    output logic [63:0]        rd_data_o,
    input  logic               trap_irq_i,
    input  logic [CAUSE_W-1:0] trap_cause_i,
    output logic [63:0]        trap_target_o
);

    tvec_t reg_q;
    tvec_t reg_d;
    tvec_t legal_nxt;

    stv_wr_legal #(
        .VA_W      (VA_W),
        .DIRECT_EN (DIRECT_EN),
        .VECTOR_EN (VECTOR_EN)
    ) u_legal (
        .cur_i     (reg_q),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .nxt_o     (legal_nxt)
    );

    stv_target_gen #(
        .CAUSE_W (CAUSE_W)
    ) u_target (
        .cur_i    (reg_q),
        .irq_i    (trap_irq_i),
        .cause_i  (trap_cause_i),
        .target_o (trap_target_o)
    );

    always_comb begin
        reg_d = legal_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rd_data_o = reg_q;

endmodule

// File: rtl/stv_chk.sv
module stv_chk #(
    parameter int unsigned CAUSE_W = 6
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               wr_en_i,
    input logic [63:0]        wr_data_i,
    input logic [63:0]        rd_data_o,
    input logic               trap_irq_i,
    input logic [CAUSE_W-1:0] trap_cause_i,
    input logic [63:0]        trap_target_o
);

    logic non_canon;
    assign non_canon = !((&wr_data_i[63:48]) || !(|wr_data_i[63:48]));

    // R3
    base_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && non_canon) |=> rd_data_o[63:2] == $past(rd_data_o[63:2]));

    // R5
    mode_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[1]) |=> $stable(rd_data_o[1:0]));

    // R5
    mode_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[1] == 1'b0);

    // R11
    idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(rd_data_o));

    // R7
    direct_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o[1:0] == 2'd0) |-> trap_target_o == {rd_data_o[63:2], 2'b00});

    // R8
    vec_irq_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o[1:0] == 2'd1 && trap_irq_i) |->
            trap_target_o == {rd_data_o[63:2], 2'b00} + (64'(trap_cause_i) << 2));

    // R9
    vec_exc_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o[1:0] == 2'd1 && !trap_irq_i) |-> trap_target_o == {rd_data_o[63:2], 2'b00});

endmodule

bind strap_vec_reg stv_chk #(.CAUSE_W(CAUSE_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .rd_data_o     (rd_data_o),
    .trap_irq_i    (trap_irq_i),
    .trap_cause_i  (trap_cause_i),
    .trap_target_o (trap_target_o)
);

// File: tb/strap_vec_reg_test.sv
`timescale 1ns/1ps
module strap_vec_reg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        irq = 1'b0;
    logic [5:0]  cause = '0;
    logic [63:0] rd_a, tgt_a, rd_b, tgt_b;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] m_a = '0;
    logic [63:0] m_b = '0;

    always #2.5 clk = ~clk;

    strap_vec_reg uut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_a), .trap_irq_i(irq), .trap_cause_i(cause), .trap_target_o(tgt_a));

    strap_vec_reg #(.VECTOR_EN(1'b0)) uut_dir (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_b), .trap_irq_i(irq), .trap_cause_i(cause), .trap_target_o(tgt_b));

    function automatic bit is_canon(input logic [63:0] x);
        return (x[63:49] == {15{x[48]}});
    endfunction

    function automatic logic [63:0] legalize(input logic [63:0] cur, input logic [63:0] w,
                                             input bit vec_ok);
        logic [63:0] r = cur;
        if (is_canon(w)) r[63:2] = w[63:2];
        if (w[1:0] == 2'd0 || (vec_ok && w[1:0] == 2'd1)) r[1:0] = w[1:0];
        return r;
    endfunction

    function automatic logic [63:0] exp_tgt(input logic [63:0] st, input logic i,
                                            input logic [5:0] c);
        logic [63:0] b = {st[63:2], 2'b00};
        if (st[1:0] == 2'd1 && i) return b + ({58'd0, c} << 2);
        return b;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [63:0] canon_val(input logic [63:0] r);
        return {{15{r[48]}}, r[48:0]};
    endfunction

    // drive at negedge, check target before edge, then check read after edge
    task automatic step(input logic we, input logic [63:0] wd, input logic i,
                        input logic [5:0] c, input string req);
        @(negedge clk);
        wr_en = we; wr_data = wd; irq = i; cause = c;
        #1;
        check({req, " tgt R10"}, tgt_a, exp_tgt(m_a, i, c));
        check({req, " tgt dir"}, tgt_b, exp_tgt(m_b, i, c));
        @(posedge clk);
        if (we) begin
            m_a = legalize(m_a, wd, 1'b1);
            m_b = legalize(m_b, wd, 1'b0);
        end
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check({req, " read"}, rd_a, m_a);
        check({req, " read dir"}, rd_b, m_b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #1;
        // R1 reset state
        check("R1 read", rd_a, 64'd0);
        check("R1 tgt", tgt_a, 64'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 legal write, vectored
        step(1'b1, 64'h0000_1234_5678_9AB1, 1'b1, 6'd5, "R2 R4");
        // R8 vectored interrupt, max cause
        step(1'b0, 64'h0, 1'b1, 6'd63, "R8");
        // R9 vectored exception
        step(1'b0, 64'h0, 1'b0, 6'd63, "R9");
        // R3 non-canonical upper bits, mode 1 keeps mode: R6
        step(1'b1, 64'h8000_0000_0000_1001, 1'b0, 6'd0, "R3 R6");
        // R6 canonical base with illegal mode 3
        step(1'b1, 64'hFFFF_8000_0000_0103, 1'b1, 6'd7, "R5 R6");
        // R5 mode 2 kept out
        step(1'b1, 64'h0000_0000_0000_0402, 1'b1, 6'd1, "R5");
        // R4 direct accepted, R7 direct target for interrupt
        step(1'b1, 64'h0000_0000_0000_0800, 1'b1, 6'd9, "R4");
        step(1'b0, 64'h0, 1'b1, 6'd9, "R7");
        // R8 wrap at top of address space
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFF1, 1'b1, 6'd2, "R8 wrap");
        step(1'b0, 64'h0, 1'b1, 6'd63, "R8 wrap");
        // R11 strobe low ignores bus
        step(1'b0, 64'h0000_0000_0000_0000, 1'b0, 6'd0, "R11");
        // R10 mode switch in same cycle as trap
        step(1'b1, 64'h0000_0000_0000_4000, 1'b1, 6'd3, "R10");

        for (int k = 0; k < 400; k++) begin
            logic [63:0] w = rnd64();
            if ($urandom_range(0, 1) == 0) w = canon_val(w);
            step($urandom_range(0, 3) != 0, w, $urandom_range(0, 1) == 1,
                 6'($urandom), "R2 R3 R5 R7 R8 R9 R11 rnd");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule